// File: doc/BRIEF.md
# Slotted Ring Remote Read Network

This block joins a set of processing nodes so that any node's processor can read a word held in another node's cell memory. The nodes sit on a unidirectional ring with one register stage per node. Every clock, each stage passes its contents to the next node's stage, and the last stage wraps back to the first. A stage carries one packet: a request flag, an acknowledge flag, an address field and a data field. Requests and replies use the same circulating slots. A slot counts as free only when both flags are clear.

Each node has two sides. The processor side accepts one read at a time. It places the read into its own stage once that stage is free, then holds its busy output high until the matching reply arrives. A request carries the target address and the requester's node number. The memory side watches the passing traffic. It takes a request whose target node number is its own and runs a fixed-latency read on its local cell memory. It then sends the data back with the requester's number in the address field. While a read is in progress, further requests for the node keep circulating until it is free again. A node always sends a finished reply before it sends a new request of its own. Requests to the node's own memory also go round the ring.

A cell address is a node number in the upper bits followed by a local index in the lower bits. The cell memories are outside the block, one read port per node.

Top module: `ring_read_net`

## Requirements
- R1: While reset is asserted, every `busy`, `rsp_valid` and `mem_rd_en` bit is 0.
- R2: A node takes a request only when `req_valid` is high and its `busy` is low. `busy` goes high on the next cycle and stays high until the cycle in which `rsp_valid` pulses, when it drops. While `busy` is high, `req_valid` is ignored: no extra reply appears and the reply data is unchanged.
- R3: Each accepted request produces exactly one one-cycle `rsp_valid` pulse. With it, `rsp_data` carries the word that the target node's memory returns for the request's local index. The target node is `req_addr[AW-1 -: IW]` and the local index is `req_addr[LW-1:0]`, with IW = clog2(NODES) and LW = clog2(CELLS).
- R4: On an idle ring, a request to another node shows `rsp_valid` exactly LAT+NODES+2 clock edges after the edge that accepted it.
- R5: A request to the node's own memory travels the whole ring twice and shows `rsp_valid` exactly LAT+2*NODES+2 edges after acceptance.
- R6: For each request it serves, a node holds `mem_rd_en` high for exactly LAT consecutive cycles. During that time `mem_rd_addr` is stable and equals the requested local index. It captures `mem_rd_data` in the last of those cycles.
- R7: Requests that reach a node while it is serving another read stay on the ring and are served later. Simultaneous requests from every node to one target all complete.
- R8: A node's memory side serves remote requests while its own processor side has a request outstanding, and neither side blocks the other.
- R9: Under random traffic from all nodes, every request is answered exactly once with correct data, and the ring never locks up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NODES | Per node: read request strobe from the processor |
| req_addr | input | NODES*AW | Per node: cell address, {node number, local index} |
| busy | output | NODES | Per node: request outstanding, processor stalls |
| rsp_valid | output | NODES | Per node: one-cycle reply strobe |
| rsp_data | output | NODES*DW | Per node: reply word |
| mem_rd_en | output | NODES | Per node: local memory read in progress |
| mem_rd_addr | output | NODES*LW | Per node: local memory index, held during the read |
| mem_rd_data | input | NODES*DW | Per node: local memory read word |

## Verification
A packet left in the wrong state in a stage shows up as a missing, duplicated or misrouted reply. The requester's `busy` then stays high forever, or `rsp_valid` pulses with wrong data or with nothing outstanding. Timing faults in the forwarding, removal or injection logic move the idle-ring reply edge away from LAT+NODES+2. That shows within a dozen cycles of the first directed request. A fault in the serving sequencer shows at the memory port at once, as a wrong read length or an address that moves during a read. Contention faults, such as a lost slot while a node is busy or starvation, show as a node whose `busy` never clears during the all-to-one and random traffic runs.

// File: rtl/ring_pkg.sv
package ring_pkg;

  // Memory-side sequencer of one ring node
  typedef enum logic [1:0] {
    SRV_IDLE  = 2'd0,
    SRV_READ  = 2'd1,
    SRV_REPLY = 2'd2
  } srv_state_e;

endpackage

// File: rtl/ring_req_side.sv
// Processor side of a ring node: one outstanding read, injection, reply pickup.
module ring_req_side #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          inj_grant,
  input  logic          ack_hit,
  input  logic [DW-1:0] ack_data,
  output logic          inj_want,
  output logic [AW-1:0] inj_addr,
  output logic          ack_take,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic          pend_q, pend_d;
  logic          wait_q, wait_d;
  logic          rspv_q;
  logic          accept;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    busy     = pend_q | wait_q;
    accept   = req_valid & ~busy;
    ack_take = ack_hit & wait_q;
    inj_want = pend_q;
    inj_addr = addr_q;
    pend_d   = pend_q;
    if (accept)         pend_d = 1'b1;
    else if (inj_grant) pend_d = 1'b0;
    wait_d   = wait_q;
    if (inj_grant)      wait_d = 1'b1;
    else if (ack_take)  wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      rspv_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      wait_q <= wait_d;
      rspv_q <= ack_take;
    end
  end

  always_ff @(posedge clk) begin
    if (accept)   addr_q <= req_addr;
    if (ack_take) data_q <= ack_data;
  end

  assign rsp_valid = rspv_q;
  assign rsp_data  = data_q;

endmodule

// File: rtl/ring_srv_side.sv
// Memory side of a ring node: takes one request, runs a fixed-latency read, queues the reply.
module ring_srv_side
  import ring_pkg::*;
#(
  parameter int IW  = 2,
  parameter int LW  = 4,
  parameter int DW  = 16,
  parameter int LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_hit,
  input  logic [IW-1:0] req_src,
  input  logic [LW-1:0] req_local,
  input  logic          reply_grant,
  input  logic [DW-1:0] mem_rd_data,
  output logic          take,
  output logic          reply_want,
  output logic [IW-1:0] reply_id,
  output logic [DW-1:0] reply_data,
  output logic          mem_rd_en,
  output logic [LW-1:0] mem_rd_addr
);

  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LAT - 1);

  srv_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] id_q;
  logic [LW-1:0] la_q;
  logic [DW-1:0] data_q;
  logic          cap_en;

  always_comb begin
    take    = req_hit && (state_q == SRV_IDLE);
    cap_en  = (state_q == SRV_READ) && (cnt_q == LAST);
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      SRV_IDLE:  if (take) begin state_d = SRV_READ; cnt_d = '0; end
      SRV_READ:  if (cnt_q == LAST) state_d = SRV_REPLY;
                 else cnt_d = cnt_q + 1'b1;
      SRV_REPLY: if (reply_grant) state_d = SRV_IDLE;
      default:   state_d = SRV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SRV_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      id_q <= req_src;
      la_q <= req_local;
    end
    if (cap_en) data_q <= mem_rd_data;
  end

  assign reply_want  = (state_q == SRV_REPLY);
  assign reply_id    = id_q;
  assign reply_data  = data_q;
  assign mem_rd_en   = (state_q == SRV_READ);
  assign mem_rd_addr = la_q;

endmodule

// File: rtl/ring_node.sv
// One ring stop: slot decode, removal, injection and the stage register.
module ring_node #(
  parameter int IW    = 2,
  parameter int LW    = 4,
  parameter int DW    = 16,
  parameter int LAT   = 2,
  parameter int MY_ID = 0,
  localparam int AW   = IW + LW,
  localparam int SW   = 2 + AW + DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] slot_in,
  output logic [SW-1:0] slot_out,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_rd_en,
  output logic [LW-1:0] mem_rd_addr,
  input  logic [DW-1:0] mem_rd_data
);

  localparam int F_REQ = SW - 1;
  localparam int F_ACK = SW - 2;

  logic          in_req, in_ack, mine;
  logic [AW-1:0] in_addr;
  logic [DW-1:0] in_data;
  logic          req_hit, ack_hit, take, ack_take;
  logic          inj_want, inj_grant, reply_want, reply_grant, slot_free;
  logic [AW-1:0] inj_addr;
  logic [IW-1:0] reply_id;
  logic [DW-1:0] reply_data;
  logic [SW-1:0] mid, slot_d, slot_q;

  always_comb begin
    in_req  = slot_in[F_REQ];
    in_ack  = slot_in[F_ACK];
    in_addr = slot_in[DW +: AW];
    in_data = slot_in[DW-1:0];
    mine    = (in_addr[AW-1 -: IW] == IW'(MY_ID));
    req_hit = in_req & mine;
    ack_hit = in_ack & mine;
  end

  always_comb begin
    mid = slot_in;
    if (take)     mid[F_REQ] = 1'b0;
    if (ack_take) mid[F_ACK] = 1'b0;
    slot_free   = ~mid[F_REQ] & ~mid[F_ACK];
    reply_grant = slot_free & reply_want;
    inj_grant   = slot_free & ~reply_want & inj_want;
    slot_d      = mid;
    if (reply_grant)    slot_d = {1'b0, 1'b1, reply_id, {LW{1'b0}}, reply_data};
    else if (inj_grant) slot_d = {1'b1, 1'b0, inj_addr, DW'(MY_ID)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot_out = slot_q;

  ring_req_side #(.AW(AW), .DW(DW)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .inj_grant (inj_grant),
    .ack_hit   (ack_hit),
    .ack_data  (in_data),
    .inj_want  (inj_want),
    .inj_addr  (inj_addr),
    .ack_take  (ack_take),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  ring_srv_side #(.IW(IW), .LW(LW), .DW(DW), .LAT(LAT)) u_srv (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_hit     (req_hit),
    .req_src     (in_data[IW-1:0]),
    .req_local   (in_addr[LW-1:0]),
    .reply_grant (reply_grant),
    .mem_rd_data (mem_rd_data),
    .take        (take),
    .reply_want  (reply_want),
    .reply_id    (reply_id),
    .reply_data  (reply_data),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr)
  );

endmodule

// File: rtl/ring_read_net.sv
// Ring of NODES stops; stage N feeds stop (N+1) mod NODES.
module ring_read_net #(
  parameter int NODES = 4,
  parameter int CELLS = 16,
  parameter int DW    = 16,
  parameter int LAT   = 2,
  localparam int IW   = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int LW   = (CELLS > 1) ? $clog2(CELLS) : 1,
  localparam int AW   = IW + LW,
  localparam int SW   = 2 + AW + DW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NODES-1:0]    req_valid,
  input  logic [NODES*AW-1:0] req_addr,
  output logic [NODES-1:0]    busy,
  output logic [NODES-1:0]    rsp_valid,
  output logic [NODES*DW-1:0] rsp_data,
  output logic [NODES-1:0]    mem_rd_en,
  output logic [NODES*LW-1:0] mem_rd_addr,
  input  logic [NODES*DW-1:0] mem_rd_data
);

  logic [SW-1:0] stage [NODES];

  for (genvar n = 0; n < NODES; n++) begin : g_node
    ring_node #(
      .IW(IW), .LW(LW), .DW(DW), .LAT(LAT), .MY_ID(n)
    ) u_node (
      .clk         (clk),
      .rst_n       (rst_n),
      .slot_in     (stage[(n + NODES - 1) % NODES]),
      .slot_out    (stage[n]),
      .req_valid   (req_valid[n]),
      .req_addr    (req_addr[n*AW +: AW]),
      .busy        (busy[n]),
      .rsp_valid   (rsp_valid[n]),
      .rsp_data    (rsp_data[n*DW +: DW]),
      .mem_rd_en   (mem_rd_en[n]),
      .mem_rd_addr (mem_rd_addr[n*LW +: LW]),
      .mem_rd_data (mem_rd_data[n*DW +: DW])
    );
  end

endmodule

// File: rtl/ring_read_net_chk.sv
module ring_read_net_chk #(
  parameter int NODES = 4,
  parameter int CELLS = 16,
  parameter int LAT   = 2,
  localparam int LW   = (CELLS > 1) ? $clog2(CELLS) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NODES-1:0]    req_valid,
  input logic [NODES-1:0]    busy,
  input logic [NODES-1:0]    rsp_valid,
  input logic [NODES-1:0]    mem_rd_en,
  input logic [NODES*LW-1:0] mem_rd_addr
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (busy == '0 && rsp_valid == '0 && mem_rd_en == '0));

  for (genvar n = 0; n < NODES; n++) begin : g_chk
    logic [31:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= '0;
      else if (mem_rd_en[n]) run_q <= run_q + 1;
      else                 run_q <= '0;
    end

    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[n] && !busy[n] |=> busy[n]);

    a_r2_busy_drops_with_reply: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[n]) |-> rsp_valid[n]);

    a_r3_reply_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[n] |-> $past(busy[n]));

    a_r6_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en[n] && $past(mem_rd_en[n]) |-> $stable(mem_rd_addr[n*LW +: LW]));

    a_r6_read_not_long: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en[n] |-> run_q < 32'(LAT));

    a_r6_read_not_short: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_rd_en[n] && run_q != 0 |-> run_q == 32'(LAT));
  end

endmodule

bind ring_read_net ring_read_net_chk #(
  .NODES(NODES), .CELLS(CELLS), .LAT(LAT)
) u_chk (.*);

// File: tb/ring_read_net_test.sv
module ring_read_net_test;
  localparam int CLK_PERIOD = 10;
  localparam int NODES = 4;
  localparam int CELLS = 16;
  localparam int DW    = 16;
  localparam int LAT   = 2;
  localparam int IW    = 2;
  localparam int LW    = 4;
  localparam int AW    = IW + LW;
  localparam int NRAND = 24;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [NODES-1:0]    req_valid;
  logic [NODES*AW-1:0] req_addr;
  logic [NODES-1:0]    busy, rsp_valid, mem_rd_en;
  logic [NODES*DW-1:0] rsp_data, mem_rd_data;
  logic [NODES*LW-1:0] mem_rd_addr;

  int errors = 0;
  int checks = 0;
  logic          outstanding [NODES];
  logic [DW-1:0] expect_d    [NODES];
  int            rsp_cnt     [NODES];
  int            rd_cycles   [NODES];
  logic [31:0]   seed = 32'h1badcafe;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_read_net #(.NODES(NODES), .CELLS(CELLS), .DW(DW), .LAT(LAT)) uut (.*);

  function automatic logic [DW-1:0] memf(input int node, input int la);
    return DW'(node * 4957 + la * 263) ^ 16'hA5C3;
  endfunction

  always_comb begin
    for (int n = 0; n < NODES; n++)
      mem_rd_data[n*DW +: DW] = memf(n, int'(mem_rd_addr[n*LW +: LW]));
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int n = 0; n < NODES; n++) begin
        if (mem_rd_en[n]) rd_cycles[n]++;
        if (rsp_valid[n]) begin
          rsp_cnt[n]++;
          if (!outstanding[n]) chk(1'b0, "R3 reply without request", n, -1);
          else chk(rsp_data[n*DW +: DW] == expect_d[n], "R3 reply data",
                   rsp_data[n*DW +: DW], expect_d[n]);
          outstanding[n] = 1'b0;
        end
      end
    end
  end

  task automatic issue(input int n, input int tgt, input int la);
    req_valid[n] = 1'b1;
    req_addr[n*AW +: AW] = {IW'(tgt), LW'(la)};
    outstanding[n] = 1'b1;
    expect_d[n] = memf(tgt, la);
  endtask

  task automatic next_rand(output int v);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    v = int'(seed[15:0]);
  endtask

  task automatic wait_all(input int limit, input string tag);
    int cyc = 0;
    bit pend = 1'b1;
    while (pend && cyc < limit) begin
      @(negedge clk);
      cyc++;
      pend = 1'b0;
      for (int n = 0; n < NODES; n++) if (outstanding[n]) pend = 1'b1;
    end
    chk(!pend, tag, cyc, limit);
  endtask

  task automatic t_reset();
    rst_n = 1'b1;
    req_valid = '0;
    req_addr = '0;
    for (int n = 0; n < NODES; n++) begin
      outstanding[n] = 1'b0; rsp_cnt[n] = 0; rd_cycles[n] = 0; expect_d[n] = '0;
    end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == '0, "R1 busy in reset", busy, 0);
    chk(rsp_valid == '0, "R1 rsp_valid in reset", rsp_valid, 0);
    chk(mem_rd_en == '0, "R1 mem_rd_en in reset", mem_rd_en, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == '0 && rsp_valid == '0, "R1 idle after reset", {busy, rsp_valid}, 0);
  endtask

  // Edge count from acceptance to reply; R4 remote, R5 own node; R6 read port
  task automatic t_latency(input int src, input int tgt, input int la, input int k, input string tag);
    int cyc = 0;
    int snap = rd_cycles[tgt];
    issue(src, tgt, la);
    forever begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      req_valid[src] = 1'b0;
      if (cyc == 1) chk(busy[src], "R2 busy after accept", busy[src], 1);
      if (mem_rd_en[tgt])
        chk(mem_rd_addr[tgt*LW +: LW] == LW'(la), "R6 read address",
            mem_rd_addr[tgt*LW +: LW], la);
      if (rsp_valid[src] || cyc > 100) break;
    end
    chk(cyc - 1 == k, tag, cyc - 1, k);
    chk(!busy[src], "R2 busy drops with reply", busy[src], 0);
    repeat (4) @(negedge clk);
    chk(rd_cycles[tgt] - snap == LAT, "R6 read length", rd_cycles[tgt] - snap, LAT);
  endtask

  task automatic t_ignore();
    int snap = rsp_cnt[0];
    @(negedge clk);
    issue(0, 2, 5);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      req_valid[0] = 1'b1;
      req_addr[0 +: AW] = {IW'(3), LW'(9)};
    end
    @(negedge clk);
    req_valid[0] = 1'b0;
    wait_all(200, "R2 reply while ignoring");
    repeat (40) @(negedge clk);
    chk(rsp_cnt[0] - snap == 1, "R2 requests while busy ignored", rsp_cnt[0] - snap, 1);
  endtask

  task automatic t_all_to_one();
    int snap [NODES];
    int rsnap = rd_cycles[3];
    @(negedge clk);
    for (int n = 0; n < NODES; n++) begin
      snap[n] = rsp_cnt[n];
      issue(n, 3, n + 1);
    end
    @(negedge clk);
    req_valid = '0;
    wait_all(400, "R7 all-to-one completes");
    repeat (4) @(negedge clk);
    for (int n = 0; n < NODES; n++)
      chk(rsp_cnt[n] - snap[n] == 1, "R7 one reply per node", rsp_cnt[n] - snap[n], 1);
    chk(rd_cycles[3] - rsnap == NODES * LAT, "R7 target served each",
        rd_cycles[3] - rsnap, NODES * LAT);
  endtask

  task automatic t_cross();
    int snap [NODES];
    @(negedge clk);
    for (int n = 0; n < NODES; n++) snap[n] = rsp_cnt[n];
    issue(0, 1, 7);
    issue(1, 0, 3);
    issue(2, 0, 12);
    issue(3, 1, 15);
    @(negedge clk);
    req_valid = '0;
    wait_all(400, "R8 cross traffic completes");
    for (int n = 0; n < NODES; n++)
      chk(rsp_cnt[n] - snap[n] == 1, "R8 serve while waiting", rsp_cnt[n] - snap[n], 1);
  endtask

  task automatic t_random();
    int issued [NODES];
    int snap   [NODES];
    int cyc = 0;
    bit live = 1'b1;
    int v1, v2;
    for (int n = 0; n < NODES; n++) begin issued[n] = 0; snap[n] = rsp_cnt[n]; end
    while (live && cyc < 8000) begin
      @(negedge clk);
      cyc++;
      req_valid = '0;
      live = 1'b0;
      for (int n = 0; n < NODES; n++) begin
        if (!busy[n] && !outstanding[n] && issued[n] < NRAND) begin
          next_rand(v1);
          next_rand(v2);
          issue(n, v1 % NODES, v2 % CELLS);
          issued[n]++;
        end
        if (issued[n] < NRAND || outstanding[n]) live = 1'b1;
      end
    end
    req_valid = '0;
    chk(!live, "R9 random traffic drains", cyc, 8000);
    for (int n = 0; n < NODES; n++)
      chk(rsp_cnt[n] - snap[n] == NRAND, "R9 reply count", rsp_cnt[n] - snap[n], NRAND);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    t_reset();
    @(negedge clk);
    t_latency(0, 2, 5, LAT + NODES + 2, "R4 remote latency");
    @(negedge clk);
    t_latency(3, 1, 11, LAT + NODES + 2, "R4 remote latency wrap");
    @(negedge clk);
    t_latency(1, 1, 4, LAT + 2 * NODES + 2, "R5 own-node latency");
    t_ignore();
    t_all_to_one();
    t_cross();
    t_random();
    repeat (5) @(negedge clk);
    summary();
  end

endmodule